// File: doc/BRIEF.md
# Shared-Bus Three-Register Transfer Datapath

Three W-bit registers (W = 8 by default) sit around one multiplexed bus. Each cycle a 2-bit select places one register, or a constant zero, on the bus. A function unit combines that bus value with the contents of the third register and produces one result word. On the next rising clock edge that word is written into every register whose load line is high.

Because the bus is shared, only one source value exists per cycle. Several registers may capture that same value together, but no two different words can move in one cycle. Registers that are not loaded keep their value through a feedback multiplexer, and the clock is never gated.

A single control-enable input qualifies every transfer. Carry and zero flags are captured together with each write.

Top module: `xfer_datapath`

## Requirements
- R1: When `rst` is high at a rising edge, all three registers and both flags become zero on that edge.
- R2: `bus_sel` values 0, 1 and 2 put register 0, 1 or 2 on the bus, and value 3 puts all zeros on it. The result word is written on the edge into every register whose `load_en` bit is set (bit i controls register i), all in the same cycle.
- R3: A register whose `load_en` bit is low keeps its value across the edge.
- R4: While `ctl_en` is low, no register and no flag changes.
- R5: `op_sel` = 0 transfers the bus unchanged. `op_sel` = 1 adds: with `sub_mode` = 0 the result is bus + register 2; with `sub_mode` = 1 it is bus + (NOT register 2) + 1, that is bus − register 2 modulo 2^W.
- R6: `op_sel` = 2 gives bus + 1, `op_sel` = 3 gives bus − 1, and `op_sel` = 4 gives the bitwise NOT of the bus, all modulo 2^W.
- R7: `op_sel` = 5, 6 and 7 give bus OR, bus AND and bus XOR register 2, applied bit by bit.
- R8: `op_sel` = 8 shifts the bus left by one and `op_sel` = 9 shifts it right by one. In both cases the vacated bit is filled with zero.
- R9: `op_sel` codes 10 to 15 are reserved. They write no register and leave the flags unchanged.
- R10: A write (`ctl_en` high, a valid code and at least one load bit set) updates both flags. `flag_zero` is set when the result is zero. `flag_carry` is the carry out of bit W-1 for add, subtract (1 means no borrow), increment and decrement (the decrement is bus + all-ones), and is 0 for every other code. When no write occurs, the flags hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock, free running |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 2 | Bus source: register 0/1/2, or 3 for zero |
| load_en | input | 3 | Per-register load enable, bit i for register i |
| op_sel | input | 4 | Function code |
| sub_mode | input | 1 | Chooses subtract for the add/subtract code |
| ctl_en | input | 1 | Control enable qualifying all transfers |
| r0_q | output | W | Register 0 contents |
| r1_q | output | W | Register 1 contents |
| r2_q | output | W | Register 2 contents |
| flag_carry | output | 1 | Registered carry flag |
| flag_zero | output | 1 | Registered zero flag |

## Verification
The stimulus steers values through wrap-around points:
- Incrementing all-ones tests whether the design keeps the carry. A design that dropped the carry would leave `flag_carry` low.
- Decrementing zero tests the borrow. A design that treated the borrow wrongly would report a carry.
- Subtracting a register from itself tests the added one. A design that forgot the +1 would produce all-ones instead of zero.

Right shifts of words with the top bit set expose a design that sign-fills instead of zero-filling. Writes to several registers at once expose a design that drops a load. Vectors with `ctl_en` low, with no load bit set and with reserved codes catch a design that still writes or still updates the flags. Resetting mid-run from a non-zero state confirms the clear.

// File: rtl/xdp_pkg.sv
package xdp_pkg;
    localparam int NREG = 3;
    localparam int SELW = 2;
    localparam int OPW  = 4;

    typedef enum logic [OPW-1:0] {
        OP_MOVE   = 4'd0,
        OP_ADDSUB = 4'd1,
        OP_INC    = 4'd2,
        OP_DEC    = 4'd3,
        OP_NOT    = 4'd4,
        OP_OR     = 4'd5,
        OP_AND    = 4'd6,
        OP_XOR    = 4'd7,
        OP_SHL    = 4'd8,
        OP_SHR    = 4'd9
    } xop_e;

    typedef struct packed {
        logic carry;
        logic zero;
    } flags_t;

    function automatic logic op_is_valid(logic [OPW-1:0] code);
        return code <= OP_SHR;
    endfunction
endpackage

// File: rtl/xdp_bus_mux.sv
module xdp_bus_mux
    import xdp_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [NREG-1:0][W-1:0] regs,
    input  logic [SELW-1:0]        sel,
    output logic [W-1:0]           bus
);
    always_comb begin
        bus = '0;
        for (int i = 0; i < NREG; i++) begin
            if (sel == SELW'(i)) bus = regs[i];
        end
    end
endmodule

// File: rtl/xdp_func_unit.sv
module xdp_func_unit
    import xdp_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic [OPW-1:0] op,
    input  logic           sub_mode,
    output logic [W-1:0]   res,
    output flags_t         fl,
    output logic           valid
);
    localparam int EW = W + 1;

    logic [EW-1:0] ext;
    logic [W-1:0]  b_eff;
    logic          arith;

    assign b_eff = sub_mode ? ~b : b;

    always_comb begin
        ext   = '0;
        arith = 1'b0;
        res   = a;
        case (op)
            OP_MOVE:   res = a;
            OP_ADDSUB: begin
                ext   = {1'b0, a} + {1'b0, b_eff} + EW'(sub_mode);
                arith = 1'b1;
                res   = ext[W-1:0];
            end
            OP_INC: begin
                ext   = {1'b0, a} + EW'(1);
                arith = 1'b1;
                res   = ext[W-1:0];
            end
            OP_DEC: begin
                ext   = {1'b0, a} + {1'b0, {W{1'b1}}};
                arith = 1'b1;
                res   = ext[W-1:0];
            end
            OP_NOT:    res = ~a;
            OP_OR:     res = a | b;
            OP_AND:    res = a & b;
            OP_XOR:    res = a ^ b;
            OP_SHL:    res = {a[W-2:0], 1'b0};
            OP_SHR:    res = {1'b0, a[W-1:1]};
            default:   res = a;
        endcase
        fl.carry = arith & ext[W];
        fl.zero  = (res == '0);
    end

    assign valid = op_is_valid(op);
endmodule

// File: rtl/xdp_reg_bank.sv
module xdp_reg_bank
    import xdp_pkg::*;
#(
    parameter int W = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [NREG-1:0]        load,
    input  logic [W-1:0]           din,
    output logic [NREG-1:0][W-1:0] q
);
    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic [W-1:0] nxt;
        assign nxt = (wr_en && load[g]) ? din : q[g];
        always_ff @(posedge clk) begin
            if (rst) q[g] <= '0;
            else     q[g] <= nxt;
        end
    end
endmodule

// File: rtl/xfer_datapath.sv
module xfer_datapath
    import xdp_pkg::*;
#(
    parameter int W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [1:0]      bus_sel,
    input  logic [2:0]      load_en,
    input  logic [3:0]      op_sel,
    input  logic            sub_mode,
    input  logic            ctl_en,
    output logic [W-1:0]    r0_q,
    output logic [W-1:0]    r1_q,
    output logic [W-1:0]    r2_q,
    output logic            flag_carry,
    output logic            flag_zero
);
    localparam int OPB_IDX = NREG - 1;

    logic [NREG-1:0][W-1:0] regs;
    logic [W-1:0]           bus;
    logic [W-1:0]           res;
    flags_t                 fu_fl;
    flags_t                 fl_q;
    logic                   op_ok;
    logic                   wr_en;

    xdp_bus_mux #(.W(W)) u_mux (
        .regs (regs),
        .sel  (bus_sel),
        .bus  (bus)
    );

    xdp_func_unit #(.W(W)) u_fu (
        .a        (bus),
        .b        (regs[OPB_IDX]),
        .op       (op_sel),
        .sub_mode (sub_mode),
        .res      (res),
        .fl       (fu_fl),
        .valid    (op_ok)
    );

    assign wr_en = ctl_en && op_ok;

    xdp_reg_bank #(.W(W)) u_bank (
        .clk   (clk),
        .rst   (rst),
        .wr_en (wr_en),
        .load  (load_en),
        .din   (res),
        .q     (regs)
    );

    always_ff @(posedge clk) begin
        if (rst)                     fl_q <= '0;
        else if (wr_en && |load_en)  fl_q <= fu_fl;
    end

    assign r0_q       = regs[0];
    assign r1_q       = regs[1];
    assign r2_q       = regs[2];
    assign flag_carry = fl_q.carry;
    assign flag_zero  = fl_q.zero;
endmodule

// File: rtl/xfer_datapath_chk.sv
module xfer_datapath_chk
    import xdp_pkg::*;
#(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic [1:0]   bus_sel,
    input logic [2:0]   load_en,
    input logic [3:0]   op_sel,
    input logic         sub_mode,
    input logic         ctl_en,
    input logic [W-1:0] r0_q,
    input logic [W-1:0] r1_q,
    input logic [W-1:0] r2_q,
    input logic         flag_carry,
    input logic         flag_zero
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (r0_q == '0 && r1_q == '0 && r2_q == '0 && !flag_carry && !flag_zero));

    // R2
    move_r1_to_r0_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_en && load_en[0] && op_sel == OP_MOVE && bus_sel == 2'd1)
        |=> (r0_q == $past(r1_q)));

    // R3
    hold_r0_chk: assert property (@(posedge clk) disable iff (rst)
        !load_en[0] |=> $stable(r0_q));

    // R3
    hold_r2_chk: assert property (@(posedge clk) disable iff (rst)
        !load_en[2] |=> $stable(r2_q));

    // R4
    ctl_off_chk: assert property (@(posedge clk) disable iff (rst)
        !ctl_en |=> ($stable(r0_q) && $stable(r1_q) && $stable(r2_q)
                     && $stable(flag_carry) && $stable(flag_zero)));

    // R9
    reserved_op_chk: assert property (@(posedge clk) disable iff (rst)
        (op_sel > OP_SHR) |=> ($stable(r1_q) && $stable(flag_zero) && $stable(flag_carry)));

    // R10
    flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (load_en == 3'b000) |=> ($stable(flag_carry) && $stable(flag_zero)));
endmodule

bind xfer_datapath xfer_datapath_chk #(.W(W)) u_chk (.*);

// File: tb/test_xfer_datapath.sv
`timescale 1ns/1ps
module test_xfer_datapath;
    localparam int W  = 8;
    localparam int NV = 20;

    logic         clk = 1'b0;
    logic         rst;
    logic [1:0]   bus_sel;
    logic [2:0]   load_en;
    logic [3:0]   op_sel;
    logic         sub_mode;
    logic         ctl_en;
    logic [W-1:0] r0_q, r1_q, r2_q;
    logic         flag_carry, flag_zero;

    int checks = 0;
    int fails  = 0;
    logic done = 1'b0;

    logic [W-1:0] m [3];
    logic         mc, mz;

    always #2.5 clk = ~clk;

    xfer_datapath #(.W(W)) i_xfer_datapath (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .load_en(load_en),
        .op_sel(op_sel), .sub_mode(sub_mode), .ctl_en(ctl_en),
        .r0_q(r0_q), .r1_q(r1_q), .r2_q(r2_q),
        .flag_carry(flag_carry), .flag_zero(flag_zero)
    );

    // {bus_sel, load_en, op_sel, sub_mode, ctl_en}
    localparam logic [10:0] VEC [NV] = '{
        {2'd3, 3'b001, 4'd2, 1'b0, 1'b1},
        {2'd0, 3'b010, 4'd2, 1'b0, 1'b1},
        {2'd1, 3'b100, 4'd8, 1'b0, 1'b1},
        {2'd2, 3'b001, 4'd1, 1'b0, 1'b1},
        {2'd0, 3'b010, 4'd1, 1'b0, 1'b1},
        {2'd1, 3'b100, 4'd4, 1'b0, 1'b1},
        {2'd1, 3'b001, 4'd1, 1'b1, 1'b1},
        {2'd2, 3'b011, 4'd9, 1'b0, 1'b1},
        {2'd0, 3'b100, 4'd5, 1'b0, 1'b1},
        {2'd1, 3'b010, 4'd6, 1'b0, 1'b1},
        {2'd0, 3'b001, 4'd7, 1'b0, 1'b1},
        {2'd3, 3'b111, 4'd0, 1'b0, 1'b0},
        {2'd3, 3'b000, 4'd0, 1'b0, 1'b1},
        {2'd3, 3'b111, 4'd12, 1'b0, 1'b1},
        {2'd3, 3'b111, 4'd3, 1'b0, 1'b1},
        {2'd0, 3'b010, 4'd2, 1'b0, 1'b1},
        {2'd2, 3'b001, 4'd1, 1'b1, 1'b1},
        {2'd1, 3'b100, 4'd3, 1'b0, 1'b1},
        {2'd3, 3'b111, 4'd0, 1'b0, 1'b1},
        {2'd0, 3'b001, 4'd8, 1'b0, 1'b1}
    };

    localparam string VTAG [NV] = '{
        "R6 inc", "R6 inc", "R8 shl", "R5 add", "R5 add",
        "R6 not", "R5 sub", "R8 shr R2 multi", "R7 or", "R7 and",
        "R7 xor", "R4 ctl off", "R3 no load R10 hold", "R9 reserved", "R2 all R6 dec",
        "R10 inc carry", "R5 sub self R10", "R6 dec borrow", "R2 zero bus", "R8 shl R3"
    };

    task automatic model_step(input logic [1:0] s, input logic [2:0] ld,
                              input logic [3:0] op, input logic sm, input logic en);
        logic [W-1:0] a, b, r;
        logic [W:0]   e;
        logic         cy;
        a  = (s == 2'd3) ? '0 : m[s];
        b  = m[2];
        cy = 1'b0;
        case (op)
            4'd0: r = a;
            4'd1: begin
                e  = {1'b0, a} + {1'b0, (sm ? ~b : b)} + (W+1)'(sm);
                r  = e[W-1:0]; cy = e[W];
            end
            4'd2: begin e = {1'b0, a} + 1; r = e[W-1:0]; cy = e[W]; end
            4'd3: begin e = {1'b0, a} + {1'b0, {W{1'b1}}}; r = e[W-1:0]; cy = e[W]; end
            4'd4: r = ~a;
            4'd5: r = a | b;
            4'd6: r = a & b;
            4'd7: r = a ^ b;
            4'd8: r = a << 1;
            4'd9: r = a >> 1;
            default: r = a;
        endcase
        if (en && op <= 4'd9) begin
            for (int i = 0; i < 3; i++) if (ld[i]) m[i] = r;
            if (ld != 3'b000) begin mc = cy; mz = (r == '0); end
        end
    endtask

    task automatic compare(input string tag);
        checks++;
        if (r0_q !== m[0] || r1_q !== m[1] || r2_q !== m[2] ||
            flag_carry !== mc || flag_zero !== mz) begin
            fails++;
            $display("FAIL %s: got r0=%h r1=%h r2=%h c=%b z=%b, expected r0=%h r1=%h r2=%h c=%b z=%b",
                     tag, r0_q, r1_q, r2_q, flag_carry, flag_zero,
                     m[0], m[1], m[2], mc, mz);
        end
    endtask

    task automatic apply(input logic [10:0] v, input string tag);
        @(negedge clk);
        {bus_sel, load_en, op_sel, sub_mode, ctl_en} = v;
        @(posedge clk);
        model_step(v[10:9], v[8:6], v[5:2], v[1], v[0]);
        #1;
        compare(tag);
    endtask

    task automatic do_reset(input string tag);
        @(negedge clk);
        rst = 1'b1;
        ctl_en = 1'b1; load_en = 3'b111; op_sel = 4'd2; bus_sel = 2'd3;
        @(posedge clk);
        #1;
        for (int i = 0; i < 3; i++) m[i] = '0;
        mc = 1'b0; mz = 1'b0;
        compare(tag);
        @(negedge clk);
        rst = 1'b0;
        ctl_en = 1'b0;
    endtask

    initial begin
        rst = 1'b1; bus_sel = '0; load_en = '0; op_sel = '0; sub_mode = 1'b0; ctl_en = 1'b0;
        repeat (2) @(posedge clk);
        do_reset("R1 initial reset");

        for (int k = 0; k < NV; k++) apply(VEC[k], VTAG[k]);

        // build non-zero state, then reset mid-run (R1)
        apply({2'd3, 3'b111, 4'd3, 1'b0, 1'b1}, "R2 fill ones");
        apply({2'd0, 3'b010, 4'd9, 1'b0, 1'b1}, "R8 shr zero fill");
        do_reset("R1 mid-run reset");

        // reserved code 15 with subtract mode set (R9)
        apply({2'd3, 3'b111, 4'd15, 1'b1, 1'b1}, "R9 reserved 15");
        // ctl_en low with a valid write request (R4)
        apply({2'd3, 3'b111, 4'd2, 1'b0, 1'b0}, "R4 inc blocked");
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++; fails++;
                $display("FAIL watchdog: got timeout, expected completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule